// File: doc/BRIEF.md
# Multi-Channel Coherent Sine Synthesizer

This block turns one 32-bit frequency word into a set of sine waves that all advance in lockstep. A single phase register advances by the frequency word on every sample clock. Channel 0 follows that phase directly and carries the main modulation tone. Every further channel adds its own 32-bit phase shift to the same register value. The shift lets downstream logic make up for delays in cables and in processing, while every channel stays coherent with channel 0. Channels chosen at build time also put out the matching cosine, which gives a sine/cosine pair at the same shifted phase.

Each sample comes from a shared 1024-entry sine table. The top ten phase bits pick the table entry. The next twelve bits give a fraction, and a first-order correction built from the table's cosine value refines the sample between entries. All channels go through the same register pipeline, so a change on any input shows up on every channel after the same number of clock edges.

Top module: `dds_multiphase`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to 0 and the phase register is cleared. After reset is released, the phase register starts from 0.
- R2: At each clock edge with `rst` low, the phase register adds `ftw` modulo 2^32. A new `ftw` changes only the step size from the next edge on, and the phase that has already built up is kept, so the phase does not jump.
- R3: Table entry k (0..1023) holds round(32767*sin(2*pi*k/1024)), with ties rounded away from zero. A channel's sine entry S is taken at phase bits [31:22], and its cosine entry C is taken at that address plus 256, modulo 1024.
- R4: With F = phase bits [21:10] read as an unsigned number, the sine output is S + ((C*F*402 + 2^27) >>> 28), clamped to the range -32767..32767.
- R5: On a quadrature channel, the cosine output is C + ((-S*F*402 + 2^27) >>> 28), clamped to the range -32767..32767.
- R6: Channel 0 uses the phase register itself. Channel i (i >= 1) uses the phase register plus `phase_off[32*i-1:32*(i-1)]`, modulo 2^32. Channel c drives `sin_out[16*c+15:16*c]` and `cos_out[16*c+15:16*c]` as two's-complement values.
- R7: Let the phase register value set at edge t be the reference. Channel outputs change at edge t+4, and the offset that is added is the one sampled at edge t+1. This latency is the same on every channel, so channels with equal offsets give identical samples.
- R8: Channel c produces a cosine only when `QUAD_MASK[c]` is 1. The default mask is 4'b1010, which selects channels 1 and 3. On every other channel, the cosine output stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | 32 | Frequency tuning word, added to the phase register on each edge |
| phase_off | input | 32*N_AUX | Phase shift for each auxiliary channel; channel i uses field i-1 |
| sin_out | output | 16*(N_AUX+1) | Signed sine sample for each channel |
| cos_out | output | 16*(N_AUX+1) | Signed cosine sample for each quadrature channel, 0 on other channels |

## Verification
Two events can land on the same clock edge: the phase register taking a new tuning word, and a channel taking a new phase shift. A correct result then needs both the carried-over phase and the new shift to be used at their proper pipeline stages. The stimulus table swaps the tuning word and all three shifts together at every row boundary, with no reset in between. A cycle-accurate reference then compares every channel sample against values computed from the table formula and the interpolation rule. Fixed cases pin down exact values at a quarter turn, a half turn and a half table step, and check that every channel sees the same latency.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int PHASE_W  = 32;
    localparam int ADDR_W   = 10;
    localparam int FRAC_W   = 12;
    localparam int AMP_W    = 16;
    localparam int TAB_N    = 1 << ADDR_W;
    localparam int QTR_N    = TAB_N / 4;
    localparam int DROP_W   = PHASE_W - ADDR_W - FRAC_W;
    localparam int PH_TOP_W = ADDR_W + FRAC_W;
    localparam int AMP_PEAK = (1 << (AMP_W - 1)) - 1;
    localparam int SUM_W    = AMP_W + 2;
    // slope scale: 2*pi/TAB_N in units of 2^-SLOPE_SH
    localparam int SLOPE_SH = 16;
    localparam int SLOPE_K  = 402;
    localparam int PROD_SH  = FRAC_W + SLOPE_SH;
    localparam int PROD_W   = AMP_W + FRAC_W + 12;

    typedef logic signed [AMP_W-1:0] amp_t;
    typedef logic [PHASE_W-1:0]      phase_t;
    typedef logic [PH_TOP_W-1:0]     ph_top_t;
    typedef logic [ADDR_W-1:0]       addr_t;
    typedef logic [FRAC_W-1:0]       frac_t;

    typedef struct packed {
        amp_t s;
        amp_t c;
    } pair_t;

    function automatic amp_t sine_entry(input int k);
        real ang;
        ang = 2.0 * 3.14159265358979 * real'(k) / real'(TAB_N);
        return amp_t'(int'(real'(AMP_PEAK) * $sin(ang)));
    endfunction

    function automatic amp_t clamp_amp(input logic signed [SUM_W-1:0] v);
        if (v > SUM_W'(AMP_PEAK))
            return amp_t'(AMP_PEAK);
        else if (v < -SUM_W'(AMP_PEAK))
            return amp_t'(-AMP_PEAK);
        else
            return amp_t'(v);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t step,
    output phase_t phase
);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else
            phase <= phase + step;
    end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t rd_addr [NPORT],
    output amp_t  rd_data [NPORT]
);

    amp_t tab [TAB_N];

    initial begin
        for (int k = 0; k < TAB_N; k++)
            tab[k] = sine_entry(k);
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (rst)
                rd_data[p] <= '0;
            else
                rd_data[p] <= tab[rd_addr[p]];
        end
    end

endmodule

// File: rtl/dds_interp.sv
module dds_interp
    import dds_pkg::*;
#(
    parameter bit QUAD = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  amp_t  s_in,
    input  amp_t  c_in,
    input  frac_t frac,
    output amp_t  sin_o,
    output amp_t  cos_o
);

    localparam logic signed [PROD_W-1:0] K_SLOPE = PROD_W'(SLOPE_K);
    localparam logic signed [PROD_W-1:0] RND     = PROD_W'(1) <<< (PROD_SH - 1);

    logic signed [PROD_W-1:0] fr_ext;
    logic signed [PROD_W-1:0] c_ext;
    logic signed [PROD_W-1:0] ps_d, ps_q;
    amp_t                     s_q;

    assign fr_ext = {{(PROD_W-FRAC_W){1'b0}}, frac};
    assign c_ext  = PROD_W'(c_in);
    assign ps_d   = c_ext * fr_ext * K_SLOPE;

    // product stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
            s_q  <= '0;
        end else begin
            ps_q <= ps_d;
            s_q  <= s_in;
        end
    end

    // round, add, clamp
    always_ff @(posedge clk) begin
        if (rst)
            sin_o <= '0;
        else
            sin_o <= clamp_amp(SUM_W'(s_q) + SUM_W'((ps_q + RND) >>> PROD_SH));
    end

    generate
        if (QUAD) begin : g_quad
            logic signed [PROD_W-1:0] s_ext;
            logic signed [PROD_W-1:0] pc_q;
            amp_t                     c_q;

            assign s_ext = PROD_W'(s_in);

            always_ff @(posedge clk) begin
                if (rst) begin
                    pc_q <= '0;
                    c_q  <= '0;
                end else begin
                    pc_q <= -(s_ext * fr_ext * K_SLOPE);
                    c_q  <= c_in;
                end
            end

            always_ff @(posedge clk) begin
                if (rst)
                    cos_o <= '0;
                else
                    cos_o <= clamp_amp(SUM_W'(c_q) + SUM_W'((pc_q + RND) >>> PROD_SH));
            end
        end else begin : g_plain
            assign cos_o = '0;
        end
    endgenerate

endmodule

// File: rtl/dds_multiphase.sv
module dds_multiphase
    import dds_pkg::*;
#(
    parameter int             N_AUX     = 3,
    parameter logic [N_AUX:0] QUAD_MASK = 4'b1010
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PHASE_W-1:0]          ftw,
    input  logic [N_AUX*PHASE_W-1:0]    phase_off,
    output logic [(N_AUX+1)*AMP_W-1:0]  sin_out,
    output logic [(N_AUX+1)*AMP_W-1:0]  cos_out
);

    localparam int N_CH  = N_AUX + 1;
    localparam int NPORT = 2 * N_CH;

    phase_t  acc;
    phase_t  off_full [N_CH];
    ph_top_t ph_q     [N_CH];
    frac_t   frac_q   [N_CH];
    addr_t   rd_addr  [NPORT];
    amp_t    rd_data  [NPORT];
    pair_t   ch_out   [N_CH];

    dds_phase_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (ftw),
        .phase (acc)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_off
            if (c == 0) begin : g_main
                assign off_full[c] = '0;
            end else begin : g_aux
                assign off_full[c] = phase_off[c*PHASE_W-1 -: PHASE_W];
            end
        end
    endgenerate

    // stage 1: per-channel phase, low bits dropped
    always_ff @(posedge clk) begin
        for (int c = 0; c < N_CH; c++) begin
            if (rst)
                ph_q[c] <= '0;
            else
                ph_q[c] <= PH_TOP_W'((acc + off_full[c]) >> DROP_W);
        end
    end

    // stage 2: table reads and aligned fraction
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            rd_addr[2*c]   = ph_q[c][PH_TOP_W-1 -: ADDR_W];
            rd_addr[2*c+1] = ph_q[c][PH_TOP_W-1 -: ADDR_W] + addr_t'(QTR_N);
        end
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < N_CH; c++) begin
            if (rst)
                frac_q[c] <= '0;
            else
                frac_q[c] <= ph_q[c][FRAC_W-1:0];
        end
    end

    dds_sine_rom #(.NPORT(NPORT)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // stages 3 and 4: interpolation
    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            dds_interp #(.QUAD(QUAD_MASK[c])) u_interp (
                .clk   (clk),
                .rst   (rst),
                .s_in  (rd_data[2*c]),
                .c_in  (rd_data[2*c+1]),
                .frac  (frac_q[c]),
                .sin_o (ch_out[c].s),
                .cos_o (ch_out[c].c)
            );
            assign sin_out[c*AMP_W +: AMP_W] = ch_out[c].s;
            assign cos_out[c*AMP_W +: AMP_W] = ch_out[c].c;
        end
    endgenerate

endmodule

// File: rtl/dds_multiphase_chk.sv
module dds_multiphase_chk
    import dds_pkg::*;
#(
    parameter int             N_AUX     = 3,
    parameter logic [N_AUX:0] QUAD_MASK = 4'b1010
) (
    input logic                        clk,
    input logic                        rst,
    input logic [PHASE_W-1:0]          ftw,
    input logic [N_AUX*PHASE_W-1:0]    phase_off,
    input logic [PHASE_W-1:0]          acc,
    input ph_top_t                     ph_q [N_AUX+1],
    input logic [(N_AUX+1)*AMP_W-1:0]  sin_out,
    input logic [(N_AUX+1)*AMP_W-1:0]  cos_out
);

    localparam int N_CH     = N_AUX + 1;
    localparam int FILL_MAX = 7;
    localparam logic signed [33:0] NRM_LO = 34'sd1073414169;
    localparam logic signed [33:0] NRM_HI = 34'sd1073938441;

    logic       past_ok;
    logic [2:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            fill    <= '0;
        end else begin
            past_ok <= 1'b1;
            if (fill != 3'(FILL_MAX))
                fill <= fill + 3'd1;
        end
    end

    // two-step phase growth equals the sum of the two tuning words
    p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(past_ok)) |-> (acc - $past(acc, 2) == $past(ftw) + $past(ftw, 2)));

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            amp_t s_v, c_v;
            assign s_v = amp_t'(sin_out[c*AMP_W +: AMP_W]);
            assign c_v = amp_t'(cos_out[c*AMP_W +: AMP_W]);

            p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
                (s_v != amp_t'(-AMP_PEAK - 1)) && (c_v != amp_t'(-AMP_PEAK - 1)));

            if (c > 0) begin : g_aux
                p_offset_gap_r6: assert property (@(posedge clk) disable iff (rst)
                    past_ok |-> (PH_TOP_W'(ph_q[c] - ph_q[0]
                        - PH_TOP_W'($past(phase_off[c*PHASE_W-1 -: PHASE_W]) >> DROP_W)) <= PH_TOP_W'(1)));
            end

            if (QUAD_MASK[c]) begin : g_quad
                logic signed [33:0] nrm;
                assign nrm = 34'(s_v) * 34'(s_v) + 34'(c_v) * 34'(c_v);

                p_quad_norm_r5: assert property (@(posedge clk) disable iff (rst)
                    (fill == 3'(FILL_MAX)) |-> (nrm >= NRM_LO && nrm <= NRM_HI));
            end
        end
    endgenerate

endmodule

bind dds_multiphase dds_multiphase_chk #(.N_AUX(N_AUX), .QUAD_MASK(QUAD_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ftw       (ftw),
    .phase_off (phase_off),
    .acc       (acc),
    .ph_q      (ph_q),
    .sin_out   (sin_out),
    .cos_out   (cos_out)
);

// File: tb/tb_dds_multiphase.sv
module tb_dds_multiphase;

    localparam int CLK_P  = 10;
    localparam int N_CH   = 4;
    localparam logic [3:0] QMASK = 4'b1010;
    localparam int WDOG   = 20000;
    localparam real PI    = 3.14159265358979;

    typedef struct packed {
        logic [31:0] ftw;
        logic [31:0] o1;
        logic [31:0] o2;
        logic [31:0] o3;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0040_0000, 32'h0000_0000, 32'h4000_0000, 32'h1234_5678, 16'd40},
        '{32'h0123_4567, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 16'd60},
        '{32'hFFC0_0000, 32'h4000_0000, 32'h0020_0000, 32'hC000_0000, 16'd40},
        '{32'h7FFF_FFFF, 32'h9ABC_DEF0, 32'h0000_0400, 32'h3FFF_FC00, 16'd40},
        '{32'h0000_0400, 32'h0000_0000, 32'hBFFF_FC00, 32'h7FFF_FFFF, 16'd40},
        '{32'h0AAA_AAAB, 32'hFFC0_0000, 32'h5555_5555, 32'h0000_0000, 16'd50}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ftw = '0;
    logic [95:0] phase_off = '0;
    logic [63:0] sin_out, cos_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dds_multiphase dut (
        .clk       (clk),
        .rst       (rst),
        .ftw       (ftw),
        .phase_off (phase_off),
        .sin_out   (sin_out),
        .cos_out   (cos_out)
    );

    // reference from the requirement formulas
    function automatic int tabv(input int k);
        real a;
        a = 2.0 * PI * real'(k % 1024) / 1024.0;
        return int'(32767.0 * $sin(a));
    endfunction

    function automatic int clampv(input longint v);
        if (v > 32767) return 32767;
        if (v < -32767) return -32767;
        return int'(v);
    endfunction

    function automatic logic [31:0] ref_pair(input logic [31:0] ph, input bit quad);
        int     ad, f, s, c, so, co;
        longint ps, pc;
        ad = int'(ph[31:22]);
        f  = int'(ph[21:10]);
        s  = tabv(ad);
        c  = tabv((ad + 256) % 1024);
        ps = (longint'(c) * f * 402 + 64'sd134217728) >>> 28;
        pc = (-longint'(s) * f * 402 + 64'sd134217728) >>> 28;
        so = clampv(longint'(s) + ps);
        co = quad ? clampv(longint'(c) + pc) : 0;
        return {so[15:0], co[15:0]};
    endfunction

    logic [31:0] m_acc;
    logic [31:0] m_ph [N_CH];
    logic [31:0] e1 [N_CH];
    logic [31:0] e2 [N_CH];
    logic [31:0] e3 [N_CH];

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0;
            for (int c = 0; c < N_CH; c++) begin
                m_ph[c] <= '0; e1[c] <= '0; e2[c] <= '0; e3[c] <= '0;
            end
        end else begin
            m_acc <= m_acc + ftw;
            for (int c = 0; c < N_CH; c++) begin
                m_ph[c] <= m_acc + ((c == 0) ? 32'h0 : phase_off[c*32-1 -: 32]);
                e1[c]   <= ref_pair(m_ph[c], QMASK[c]);
                e2[c]   <= e1[c];
                e3[c]   <= e2[c];
            end
        end
    end

    function automatic logic [15:0] sin_of(input int c);
        return sin_out[c*16 +: 16];
    endfunction
    function automatic logic [15:0] cos_of(input int c);
        return cos_out[c*16 +: 16];
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what,
                     $signed(act), $signed(exp));
        end
    endtask

    // one check per cycle over all channels against the reference
    task automatic check_model(input string req);
        bit bad = 1'b0;
        checks++;
        for (int c = 0; c < N_CH; c++) begin
            if (sin_of(c) !== e3[c][31:16] || cos_of(c) !== e3[c][15:0]) begin
                if (!bad) errors++;
                bad = 1'b1;
                $display("FAIL %s ch%0d actual=%0d/%0d expected=%0d/%0d", req, c,
                         $signed(sin_of(c)), $signed(cos_of(c)),
                         $signed(e3[c][31:16]), $signed(e3[c][15:0]));
            end
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_P * WDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset
        repeat (3) @(negedge clk);
        for (int c = 0; c < N_CH; c++) begin
            check_val("R1", $sformatf("reset sin ch%0d", c), sin_of(c), 16'd0);
            check_val("R1", $sformatf("reset cos ch%0d", c), cos_of(c), 16'd0);
        end

        // R3 R8: exact table points with a frozen phase register
        phase_off = {32'hC000_0000, 32'h8000_0000, 32'h4000_0000};
        ftw = '0;
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check_val("R3", "ch0 sin at phase 0", sin_of(0), 16'd0);
        check_val("R8", "ch0 cos unused", cos_of(0), 16'd0);
        check_val("R3", "ch1 sin quarter", sin_of(1), 16'd32767);
        check_val("R5", "ch1 cos quarter", cos_of(1), 16'd0);
        check_val("R3", "ch2 sin half", sin_of(2), 16'd0);
        check_val("R8", "ch2 cos unused", cos_of(2), 16'd0);
        check_val("R3", "ch3 sin three quarter", sin_of(3), 16'hFFFF - 16'd32766);
        check_val("R5", "ch3 cos three quarter", cos_of(3), 16'd0);

        // R4 R5: half table step past zero
        phase_off[31:0] = 32'h0020_0000;
        repeat (5) @(negedge clk);
        check_val("R4", "ch1 sin half step", sin_of(1), 16'd100);
        check_val("R5", "ch1 cos half step", cos_of(1), 16'd32767);

        // R1: reset mid-run restarts the phase register at 0
        ftw = 32'h0123_4567;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_val("R1", "sin ch1 in reset", sin_of(1), 16'd0);
        check_val("R1", "cos ch1 in reset", cos_of(1), 16'd0);
        ftw = '0;
        phase_off = {32'h0, 32'h0, 32'h4000_0000};
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check_val("R1", "ch0 sin restart", sin_of(0), 16'd0);
        check_val("R1", "ch1 sin restart", sin_of(1), 16'd32767);

        // R2 R4 R5 R6 R7: vector table, inputs switched without reset
        for (int v = 0; v < 6; v++) begin
            ftw = VECS[v].ftw;
            phase_off = {VECS[v].o3, VECS[v].o2, VECS[v].o1};
            for (int n = 0; n < int'(VECS[v].n); n++) begin
                @(negedge clk);
                check_model("R2/R4/R5/R6/R7");
                if (VECS[v].o1 == 32'h0 && n > 4)
                    check_val("R7", "ch1 equals ch0 at zero offset", sin_of(1), sin_of(0));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule